// File: doc/BRIEF.md
# Control Endpoint SETUP Capture Engine

This block sits behind the packet decoder of a USB device and handles the Setup stage of control transfers. Each time a SETUP packet arrives on a control endpoint, it writes a three-word tagged record into a shared receive FIFO. The first word is a status word that names the entry kind, the endpoint and the byte count. The next two words hold the eight request bytes. Each SETUP also lowers a per-endpoint count of SETUP packets still allowed, and pulses both NAK-set strobes for that endpoint. SETUP data always goes into the FIFO. No free-space check is made and the endpoint's NAK or STALL state is not consulted, so the block has no inputs for either.

When the transfer leaves the Setup stage for a Data IN or Data OUT stage, the block adds one stage-done marker word to the FIFO. The SETUP-complete interrupt is not raised when that marker is written. It is raised when the consumer reports that it has popped the marker. At that point the block also pulses a clear for the enable bit of the endpoint's OUT direction. The interrupt stays set until software clears it by writing a one.

Input contract: SETUP events on any endpoint are at least four clocks apart. At most one stage change is signalled per record, and never in the third clock after a SETUP whose record already has a marker pending.

Top module: `setup_capture_engine`

## Requirements
- R1: A one on `cnt_load[e]` makes `setup_left` slice e (bits e*CNT_W upward) equal `cnt_load_val` from the next clock.
- R2: A SETUP event produces FIFO writes in exactly the three clocks that follow it, and lowers that endpoint's remaining count by one.
- R3: The record words are as follows. The status word has kind 1 in bits [1:0], the endpoint in bits [7:4], 8 in bits [14:8] and zero in all other bits. The second word is request bytes 0..3, with byte 0 in bits [7:0]. The third word is request bytes 4..7, with byte 4 in bits [7:0].
- R4: When the remaining count is 0, a SETUP leaves it at 0, and the SETUP's three words are still written.
- R5: A SETUP on endpoint e pulses `in_nak_set[e]` and `out_nak_set[e]` together for exactly one clock, in the clock after the event.
- R6: A stage change writes one marker word: kind 2 in bits [1:0], the endpoint in bits [7:4], count 0. When the pipeline is idle, the marker is written in the next clock. When the stage change arrives during a record or in the same clock as its SETUP, the marker is written in the clock after that record's third word.
- R7: `setup_irq[e]` becomes set in the clock after a pop with `pop_is_done` high for endpoint e. Popping a data entry does not set it.
- R8: `oep_en_clr[e]` pulses for one clock, in the same clock in which that pop sets `setup_irq[e]`.
- R9: `setup_irq[e]` stays set until `irq_clr[e]` is one. If a marker pop and a clear for the same endpoint fall in the same clock, the flag stays set.
- R10: During reset, and in the first clock after it, there are no FIFO writes, no pulses and no interrupts, and every count is 0.
- R11: If a load and a SETUP hit the same endpoint in the same clock, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_load | input | NUM_EP | Per-endpoint load strobe for the remaining count |
| cnt_load_val | input | CNT_W | Value to load |
| setup_valid | input | 1 | A SETUP packet was decoded this clock |
| setup_ep | input | EP_W | Endpoint of the SETUP |
| setup_bytes | input | 64 | Request bytes, byte 0 in bits [7:0] |
| stage_adv | input | 1 | Setup stage changed to a data stage |
| stage_ep | input | EP_W | Endpoint of the stage change |
| pop_valid | input | 1 | Consumer popped a FIFO entry |
| pop_is_done | input | 1 | The popped entry was a stage-done marker |
| pop_ep | input | EP_W | Endpoint of the popped entry |
| irq_clr | input | NUM_EP | Write-one-to-clear for the interrupt flags |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write word |
| setup_left | output | NUM_EP*CNT_W | Remaining-SETUP counts, packed per endpoint |
| in_nak_set | output | NUM_EP | IN NAK set pulse |
| out_nak_set | output | NUM_EP | OUT NAK set pulse |
| oep_en_clr | output | NUM_EP | OUT endpoint enable clear pulse |
| setup_irq | output | NUM_EP | Sticky SETUP-complete interrupt |

## Verification
Two events can coincide: a stage change, and the SETUP record that is still being streamed into the FIFO. The bench signals the stage change in the SETUP's own clock, and in each of the two clocks that follow it. A queue model checks on every clock that the marker lands right after the record's third word and never splits the record. A second collision is a marker pop and a write-one clear for the same endpoint in the same clock; it is judged by whether the interrupt flag survives.

// File: rtl/setup_cap_pkg.sv
package setup_cap_pkg;

   localparam int WORD_W      = 32;
   localparam int SETUP_BYTES = 8;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_SETUP = 2'd1,
      KIND_DONE  = 2'd2
   } entry_kind_e;

   typedef enum logic [1:0] {
      EM_IDLE = 2'd0,
      EM_W1   = 2'd1,
      EM_W2   = 2'd2,
      EM_MARK = 2'd3
   } emit_state_e;

   // status word: kind [1:0], endpoint [7:4], byte count [14:8]
   function automatic logic [WORD_W-1:0] status_word(entry_kind_e kind,
                                                     logic [3:0]  ep,
                                                     logic [6:0]  bcnt);
      logic [WORD_W-1:0] w;
      w       = '0;
      w[1:0]  = kind;
      w[7:4]  = ep;
      w[14:8] = bcnt;
      return w;
   endfunction

endpackage

// File: rtl/setup_rec_emitter.sv
module setup_rec_emitter
   import setup_cap_pkg::*;
#(
   parameter int EP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              setup_valid,
   input  logic [EP_W-1:0]   setup_ep,
   input  logic [63:0]       setup_bytes,
   input  logic              stage_adv,
   input  logic [EP_W-1:0]   stage_ep,
   output logic              fifo_wr,
   output logic [WORD_W-1:0] fifo_wdata
);

   localparam logic [6:0] SETUP_BCNT = 7'(SETUP_BYTES);

   emit_state_e     st;
   logic [63:0]     hold;
   logic            pend;
   logic [EP_W-1:0] pend_ep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= EM_IDLE;
         hold       <= '0;
         pend       <= 1'b0;
         pend_ep    <= '0;
         fifo_wr    <= 1'b0;
         fifo_wdata <= '0;
      end else begin
         fifo_wr <= 1'b0;
         unique case (st)
            EM_IDLE: begin
               if (setup_valid) begin
                  fifo_wr    <= 1'b1;
                  fifo_wdata <= status_word(KIND_SETUP, 4'(setup_ep), SETUP_BCNT);
                  hold       <= setup_bytes;
                  st         <= EM_W1;
                  if (stage_adv) begin
                     pend    <= 1'b1;
                     pend_ep <= stage_ep;
                  end
               end else if (stage_adv) begin
                  fifo_wr    <= 1'b1;
                  fifo_wdata <= status_word(KIND_DONE, 4'(stage_ep), 7'd0);
               end
            end
            EM_W1: begin
               fifo_wr    <= 1'b1;
               fifo_wdata <= hold[31:0];
               st         <= EM_W2;
               if (stage_adv && !pend) begin
                  pend    <= 1'b1;
                  pend_ep <= stage_ep;
               end
            end
            EM_W2: begin
               fifo_wr    <= 1'b1;
               fifo_wdata <= hold[63:32];
               if (pend || stage_adv) begin
                  st   <= EM_MARK;
                  pend <= 1'b1;
                  if (!pend) pend_ep <= stage_ep;
               end else begin
                  st <= EM_IDLE;
               end
            end
            EM_MARK: begin
               fifo_wr    <= 1'b1;
               fifo_wdata <= status_word(KIND_DONE, 4'(pend_ep), 7'd0);
               pend       <= 1'b0;
               st         <= EM_IDLE;
            end
            default: st <= EM_IDLE;
         endcase
      end
   end

   // input contract: a SETUP only arrives while no record is streaming
   a_r2_setup_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      setup_valid |-> st == EM_IDLE);

   // R6: a pending marker follows the third record word directly
   a_r6_marker_after_record: assert property (@(posedge clk) disable iff (!rst_n)
      (st == EM_W2 && (pend || stage_adv)) |=> ##1 (fifo_wr && fifo_wdata[1:0] == 2'd2));

endmodule

// File: rtl/setup_ep_ctrl.sv
module setup_ep_ctrl #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             setup_hit,
   input  logic             pop_done_hit,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             in_nak,
   output logic             out_nak,
   output logic             en_clr,
   output logic             irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         in_nak  <= 1'b0;
         out_nak <= 1'b0;
         en_clr  <= 1'b0;
         irq     <= 1'b0;
      end else begin
         in_nak  <= setup_hit;
         out_nak <= setup_hit;
         en_clr  <= pop_done_hit;
         irq     <= pop_done_hit | (irq & ~clr);
         if (load)
            cnt <= load_val;
         else if (setup_hit && cnt != '0)
            cnt <= cnt - 1'b1;
      end
   end

   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val));

   a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && setup_hit && !load) |=> cnt == '0);

   a_r5_nak_pair: assert property (@(posedge clk) disable iff (!rst_n)
      setup_hit |=> (in_nak && out_nak));

   a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(pop_done_hit));

   a_r8_clear_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |-> irq);

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq);

endmodule

// File: rtl/setup_capture_engine.sv
module setup_capture_engine
   import setup_cap_pkg::*;
#(
   parameter int NUM_EP = 4,
   parameter int EP_W   = 2,
   parameter int CNT_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_EP-1:0]       cnt_load,
   input  logic [CNT_W-1:0]        cnt_load_val,
   input  logic                    setup_valid,
   input  logic [EP_W-1:0]         setup_ep,
   input  logic [63:0]             setup_bytes,
   input  logic                    stage_adv,
   input  logic [EP_W-1:0]         stage_ep,
   input  logic                    pop_valid,
   input  logic                    pop_is_done,
   input  logic [EP_W-1:0]         pop_ep,
   input  logic [NUM_EP-1:0]       irq_clr,
   output logic                    fifo_wr,
   output logic [31:0]             fifo_wdata,
   output logic [NUM_EP*CNT_W-1:0] setup_left,
   output logic [NUM_EP-1:0]       in_nak_set,
   output logic [NUM_EP-1:0]       out_nak_set,
   output logic [NUM_EP-1:0]       oep_en_clr,
   output logic [NUM_EP-1:0]       setup_irq
);

   localparam int EP_SPAN = 1 << EP_W;

   generate
      if (EP_W < 1 || EP_W > 4) begin : g_bad_ep_w
         $error("EP_W must lie in 1..4 to fit the status word field");
      end
      if (NUM_EP < 1 || NUM_EP > EP_SPAN) begin : g_bad_num_ep
         $error("NUM_EP must lie in 1..2**EP_W");
      end
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("CNT_W must hold a count of three");
      end
      if (WORD_W != 32) begin : g_bad_word
         $error("record layout needs 32-bit FIFO words");
      end
   endgenerate

   logic [NUM_EP-1:0] setup_hit;
   logic [NUM_EP-1:0] pop_hit;

   setup_rec_emitter #(.EP_W(EP_W)) u_emit (
      .clk         (clk),
      .rst_n       (rst_n),
      .setup_valid (setup_valid),
      .setup_ep    (setup_ep),
      .setup_bytes (setup_bytes),
      .stage_adv   (stage_adv),
      .stage_ep    (stage_ep),
      .fifo_wr     (fifo_wr),
      .fifo_wdata  (fifo_wdata)
   );

   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      assign setup_hit[e] = setup_valid && (setup_ep == EP_W'(e));
      assign pop_hit[e]   = pop_valid && pop_is_done && (pop_ep == EP_W'(e));

      setup_ep_ctrl #(.CNT_W(CNT_W)) u_ctrl (
         .clk          (clk),
         .rst_n        (rst_n),
         .load         (cnt_load[e]),
         .load_val     (cnt_load_val),
         .setup_hit    (setup_hit[e]),
         .pop_done_hit (pop_hit[e]),
         .clr          (irq_clr[e]),
         .cnt          (setup_left[e*CNT_W +: CNT_W]),
         .in_nak       (in_nak_set[e]),
         .out_nak      (out_nak_set[e]),
         .en_clr       (oep_en_clr[e]),
         .irq          (setup_irq[e])
      );
   end

   // R2: three consecutive writes, the first one tagged as SETUP data
   a_r2_three_words: assert property (@(posedge clk) disable iff (!rst_n)
      setup_valid |=> (fifo_wr && fifo_wdata[1:0] == 2'd1) ##1 fifo_wr ##1 fifo_wr);

   // R6: a stage change on an idle pipeline writes its marker next clock
   a_r6_idle_marker: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_adv && !setup_valid && !fifo_wr) |=> (fifo_wr && fifo_wdata[1:0] == 2'd2));

   // R5: NAK strobes only ever come as a pair
   a_r5_nak_match: assert property (@(posedge clk) disable iff (!rst_n)
      in_nak_set == out_nak_set);

endmodule

// File: tb/setup_capture_engine_test.sv
`timescale 1ns/1ps
module setup_capture_engine_test;

   localparam int NUM_EP = 4;
   localparam int EP_W   = 2;
   localparam int CNT_W  = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                    rst_n;
   logic [NUM_EP-1:0]       cnt_load;
   logic [CNT_W-1:0]        cnt_load_val;
   logic                    setup_valid;
   logic [EP_W-1:0]         setup_ep;
   logic [63:0]             setup_bytes;
   logic                    stage_adv;
   logic [EP_W-1:0]         stage_ep;
   logic                    pop_valid;
   logic                    pop_is_done;
   logic [EP_W-1:0]         pop_ep;
   logic [NUM_EP-1:0]       irq_clr;
   logic                    fifo_wr;
   logic [31:0]             fifo_wdata;
   logic [NUM_EP*CNT_W-1:0] setup_left;
   logic [NUM_EP-1:0]       in_nak_set;
   logic [NUM_EP-1:0]       out_nak_set;
   logic [NUM_EP-1:0]       oep_en_clr;
   logic [NUM_EP-1:0]       setup_irq;

   setup_capture_engine #(.NUM_EP(NUM_EP), .EP_W(EP_W), .CNT_W(CNT_W)) uut (.*);

   int checks = 0;
   int fails  = 0;
   bit over   = 0;
   int post_rst = 0;

   logic [31:0]       q[$];
   logic              m_wr;
   logic [31:0]       m_data;
   int                m_cnt[NUM_EP];
   logic [NUM_EP-1:0] m_nak, m_enclr, m_irq;

   function automatic logic [31:0] sw(int kind, int ep, int bcnt);
      return 32'(kind) | (32'(ep) << 4) | (32'(bcnt) << 8);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model, advanced at each rising edge, compared 2 ns later
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_wr = 0; m_data = '0; m_nak = '0; m_enclr = '0; m_irq = '0;
         foreach (m_cnt[i]) m_cnt[i] = 0;
         post_rst = 0;
      end else begin
         if (setup_valid) begin
            q.push_back(sw(1, int'(setup_ep), 8));
            q.push_back(setup_bytes[31:0]);
            q.push_back(setup_bytes[63:32]);
         end
         if (stage_adv) q.push_back(sw(2, int'(stage_ep), 0));
         m_wr = (q.size() > 0);
         if (m_wr) m_data = q.pop_front();
         m_nak   = setup_valid ? (NUM_EP'(1) << setup_ep) : '0;
         m_enclr = (pop_valid && pop_is_done) ? (NUM_EP'(1) << pop_ep) : '0;
         m_irq   = (m_irq & ~irq_clr) | m_enclr;
         for (int e = 0; e < NUM_EP; e++) begin
            if (cnt_load[e]) m_cnt[e] = int'(cnt_load_val);
            else if (setup_valid && setup_ep == EP_W'(e) && m_cnt[e] > 0) m_cnt[e]--;
         end
         post_rst++;
      end
      #2;
      if (!rst_n || post_rst == 1) begin
         chk(fifo_wr == 1'b0 && setup_irq == '0 && in_nak_set == '0 && oep_en_clr == '0
             && setup_left == '0, "R10 reset state",
             {fifo_wr, setup_irq, in_nak_set, oep_en_clr, setup_left}, 0);
      end
      if (rst_n) begin
         chk(fifo_wr == m_wr, "R2/R6 fifo write strobe", fifo_wr, m_wr);
         if (m_wr) chk(fifo_wdata == m_data, "R3/R6 fifo word", fifo_wdata, m_data);
         for (int e = 0; e < NUM_EP; e++)
            chk(int'(setup_left[e*CNT_W +: CNT_W]) == m_cnt[e], "R1/R4/R11 remaining count",
                setup_left[e*CNT_W +: CNT_W], m_cnt[e]);
         chk(in_nak_set == m_nak && out_nak_set == m_nak, "R5 NAK pulses",
             {in_nak_set, out_nak_set}, {m_nak, m_nak});
         chk(oep_en_clr == m_enclr, "R8 enable clear pulse", oep_en_clr, m_enclr);
         chk(setup_irq == m_irq, "R7/R9 interrupt flags", setup_irq, m_irq);
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // stage_at: -1 none, else the clock offset of the stage change (0,1,2,4)
   task automatic send_setup(int ep, logic [63:0] data, int stage_at);
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         setup_valid = (c == 0);
         setup_ep    = EP_W'(ep);
         setup_bytes = data;
         stage_adv   = (c == stage_at);
         stage_ep    = EP_W'(ep);
      end
      @(negedge clk);
      setup_valid = 0; stage_adv = 0;
   endtask

   task automatic do_load(logic [NUM_EP-1:0] which, int val);
      @(negedge clk);
      cnt_load = which; cnt_load_val = CNT_W'(val);
      @(negedge clk);
      cnt_load = '0;
   endtask

   task automatic do_pop(int ep, bit done, logic [NUM_EP-1:0] clr);
      @(negedge clk);
      pop_valid = 1; pop_is_done = done; pop_ep = EP_W'(ep); irq_clr = clr;
      @(negedge clk);
      pop_valid = 0; pop_is_done = 0; irq_clr = '0;
   endtask

   task automatic finish_run();
      over = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      rst_n = 0; cnt_load = '0; cnt_load_val = '0; setup_valid = 0; setup_ep = '0;
      setup_bytes = '0; stage_adv = 0; stage_ep = '0; pop_valid = 0; pop_is_done = 0;
      pop_ep = '0; irq_clr = '0;
      idle(3);
      rst_n = 1;
      idle(3);
      // R1 load every endpoint with 3
      do_load('1, 3);
      idle(2);
      // R2/R3 three SETUPs, then R4 a fourth at count 0
      send_setup(0, 64'h0706_0504_0302_0100, -1);
      send_setup(0, 64'hF0E1_D2C3_B4A5_9687, -1);
      send_setup(0, 64'h1122_3344_5566_7788, -1);
      send_setup(0, 64'hDEAD_BEEF_CAFE_F00D, -1);
      // R6 stage change colliding with the record at each offset
      send_setup(1, 64'h0102_0304_0506_0708, 0);
      send_setup(2, 64'hA0A1_A2A3_A4A5_A6A7, 1);
      send_setup(3, 64'h5A5A_0000_FFFF_1234, 2);
      send_setup(1, 64'h8000_0000_0000_0001, 4);
      // R6 stage change on an idle pipeline
      @(negedge clk); stage_adv = 1; stage_ep = 2'd3;
      @(negedge clk); stage_adv = 0;
      idle(2);
      // R7 popping a data entry does not set the interrupt
      do_pop(0, 0, '0);
      idle(2);
      // R7/R8 marker pop sets interrupt and enable clear
      do_pop(0, 1, '0);
      idle(2);
      // R9 pop and clear for the same endpoint in one clock: flag stays
      do_pop(2, 1, 4'b0100);
      idle(2);
      // R9 clear endpoint 0 only, then endpoint 2
      @(negedge clk); irq_clr = 4'b0001;
      @(negedge clk); irq_clr = 4'b0100;
      @(negedge clk); irq_clr = '0;
      idle(2);
      // R11 load and SETUP on the same endpoint in the same clock
      @(negedge clk);
      cnt_load = 4'b0010; cnt_load_val = 2'd2;
      setup_valid = 1; setup_ep = 2'd1; setup_bytes = 64'h0BAD_F00D_1234_5678;
      @(negedge clk);
      cnt_load = '0; setup_valid = 0;
      idle(5);
      // R4 saturation on endpoint 3 from a count of 1
      do_load(4'b1000, 1);
      send_setup(3, 64'h3333_2222_1111_0000, -1);
      send_setup(3, 64'h7777_6666_5555_4444, -1);
      idle(6);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!over) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

endmodule